// File: doc/BRIEF.md
# Dual-Operator Sequential Enable

This block is a two-station interlock. Each operator station owns two buttons that must be pressed in a fixed order: the first button, then (after any pause) the second. The enable output fires one clock pulse only when both stations have finished their sequences. The stations are independent and may finish in either order or in the same cycle.

A run begins with a one-cycle start pulse, which sends a token down each station's chain of wait stages. A wait stage holds its token while its button is low and passes it on in the same cycle once the button is high. A button that is already high when the token arrives costs no cycle. The two station tokens meet in a fork-join synchroniser. The cycle in which both have arrived is registered onto the output, and after that the block stays idle until the next start pulse. A start pulse during a run drops all progress and begins a new run.

Top module: `dual_station_interlock`

## Requirements
- R1: While reset is held, and after its release, `fire_o` is low. No station holds progress until the first start pulse.
- R2: With no run in progress, button activity has no effect and `fire_o` stays low.
- R3: In `button_i`, bit 0 is station A's first button, bit 1 is A's second, bit 2 is B's first and bit 3 is B's second. A second button only counts after its station's first button has been seen high during the current run. A second-button press before that leaves the station where it is.
- R4: A button that is already high when its station's token reaches it completes that wait in the same cycle. If all four buttons are high in the start cycle, `fire_o` is high in the next cycle.
- R5: Any number of idle cycles may pass between a station's presses, and between the start pulse and a station's first press.
- R6: `fire_o` pulses only after both stations have completed their sequences, whichever station completes first.
- R7: When both stations complete in the same cycle, exactly one pulse is produced.
- R8: `fire_o` is high for exactly one cycle, starting one clock after the cycle in which the last station completes.
- R9: After the pulse, the block ignores all buttons until the next start pulse.
- R10: A start pulse during a run discards both stations' progress, and a new run begins in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle pulse that begins (or restarts) a run |
| button_i | input | STATIONS*STEPS (4) | Button levels, station-major and ordered by step |
| fire_o | output | 1 | One-cycle enable pulse |

## Verification
The assertions assume that the buttons are level signals sampled at the clock and that a start pulse can come in any cycle, including the cycle in which the output fires. The single-pulse property therefore exempts cycles where a fresh start is present. The stimulus keeps to this: every input changes only at the falling edge. Random runs use sparse button presses and occasional start pulses. Directed runs cover both completion orders, simultaneous completion, a second button pressed too early, all buttons held at start, and a restart in mid-run.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int unsigned STATIONS_DEF = 2;
  localparam int unsigned STEPS_DEF    = 2;
  localparam int unsigned RST_STAGES   = 2;

  // Position of a given step of a given station in the flat button vector.
  function automatic int unsigned btn_pos(input int unsigned stn,
                                          input int unsigned step,
                                          input int unsigned steps);
    return stn * steps + step;
  endfunction
endpackage

// File: rtl/dsi_reset_sync.sv
module dsi_reset_sync #(
  parameter int unsigned STAGES = dsi_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dsi_wait_stage.sv
// Holds a token while its level input is low; forwards it in the same
// cycle once the level is high.
module dsi_wait_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic tok_i,
  input  logic level_i,
  output logic tok_o,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;
  logic pend_en;
  logic live;

  always_comb begin
    live    = tok_i | (pend_q & ~flush_i);
    pend_d  = live & ~level_i;
    pend_en = tok_i | pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign tok_o  = live & level_i;
  assign pend_o = pend_q;

  // R5
  held_only_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !$past(level_i));
endmodule

// File: rtl/dsi_station_chain.sv
module dsi_station_chain #(
  parameter int unsigned STEPS = dsi_pkg::STEPS_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [STEPS-1:0] btn_i,
  output logic             done_o,
  output logic [STEPS-1:0] pend_o
);
  logic [STEPS:0] tok;

  assign tok[0] = start_i;

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    dsi_wait_stage u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (start_i),
      .tok_i   (tok[s]),
      .level_i (btn_i[s]),
      .tok_o   (tok[s+1]),
      .pend_o  (pend_o[s])
    );
  end

  assign done_o = tok[STEPS];

  // R3
  single_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_o));
endmodule

// File: rtl/dsi_join_sync.sv
// Fork-join: remembers which branches have finished and releases one
// joined token when all have.
module dsi_join_sync #(
  parameter int unsigned BRANCHES = dsi_pkg::STATIONS_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_i,
  input  logic [BRANCHES-1:0] fin_i,
  output logic                join_o
);
  logic [BRANCHES-1:0] seen_q;
  logic [BRANCHES-1:0] seen_d;
  logic [BRANCHES-1:0] arrived;
  logic                seen_en;
  logic                joined;

  always_comb begin
    arrived = fin_i | (seen_q & {BRANCHES{~flush_i}});
    joined  = &arrived;
    seen_d  = joined ? '0 : arrived;
    seen_en = flush_i | (|fin_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= '0;
    else if (seen_en) seen_q <= seen_d;
  end

  assign join_o = joined;

  // R7
  token_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&seen_q));
endmodule

// File: rtl/dual_station_interlock.sv
module dual_station_interlock #(
  parameter int unsigned STATIONS = dsi_pkg::STATIONS_DEF,
  parameter int unsigned STEPS    = dsi_pkg::STEPS_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [STATIONS*STEPS-1:0] button_i,
  output logic                      fire_o
);
  localparam int unsigned NBTN = STATIONS * STEPS;

  logic                      rst_int_n;
  logic [STATIONS-1:0]       stn_done;
  logic [NBTN-1:0]           stn_pend;
  logic                      joined;
  logic                      fire_q;
  logic                      fire_d;

  dsi_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar i = 0; i < STATIONS; i++) begin : g_stn
    localparam int unsigned BASE = dsi_pkg::btn_pos(i, 0, STEPS);
    dsi_station_chain #(.STEPS(STEPS)) u_chain (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .start_i (start_i),
      .btn_i   (button_i[BASE +: STEPS]),
      .done_o  (stn_done[i]),
      .pend_o  (stn_pend[BASE +: STEPS])
    );
  end

  dsi_join_sync #(.BRANCHES(STATIONS)) u_join (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .flush_i (start_i),
    .fin_i   (stn_done),
    .join_o  (joined)
  );

  always_comb begin
    fire_d = joined;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) fire_q <= 1'b0;
    else            fire_q <= fire_d;
  end

  assign fire_o = fire_q;

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fire_o && !start_i) |=> !fire_o);

  // R9
  idle_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fire_o && !start_i) |=> (stn_pend == '0));
endmodule

// File: tb/dual_station_interlock_test.sv
module dual_station_interlock_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [3:0] button_i;
  logic       fire_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  int  prog [2];
  bit  active;
  bit  exp_fire;

  dual_station_interlock uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .button_i (button_i),
    .fire_o   (fire_o)
  );

  always #10 clk = ~clk;

  // Requirement-level model of the next fire_o value.
  function automatic bit model_step(input bit st, input logic [3:0] b);
    if (st) begin
      active  = 1'b1;
      prog[0] = 0;
      prog[1] = 0;
    end
    if (active) begin
      for (int s = 0; s < 2; s++) begin
        while (prog[s] < 2 && b[s*2 + prog[s]]) prog[s]++;
      end
      if (prog[0] == 2 && prog[1] == 2) begin
        active = 1'b0;
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic check_out(input string tag);
    checks++;
    if (fire_o !== exp_fire) begin
      errors++;
      $display("FAIL %s fire_o actual %0b expected %0b at %0t", tag, fire_o, exp_fire, $time);
    end
  endtask

  // One cycle: check the output of the last edge, then drive new inputs.
  task automatic cyc(input bit st, input logic [3:0] b, input string tag);
    @(negedge clk);
    check_out(tag);
    start_i  = st;
    button_i = b;
    exp_fire = model_step(st, b);
  endtask

  task automatic idle(input int n, input logic [3:0] b, input string tag);
    for (int k = 0; k < n; k++) cyc(1'b0, b, tag);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    active = 0; exp_fire = 0; prog[0] = 0; prog[1] = 0;
    rst_n = 1'b0; start_i = 1'b0; button_i = 4'h0;
    repeat (3) @(negedge clk);
    check_out("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_out("R1");

    // R2: buttons with no run
    idle(2, 4'hF, "R2"); idle(2, 4'h5, "R2"); idle(2, 4'h0, "R2");

    // R6, R5: A completes first with pauses, then B
    cyc(1'b1, 4'h0, "R6");
    idle(3, 4'h0, "R5"); idle(1, 4'h1, "R5"); idle(4, 4'h0, "R5");
    idle(1, 4'h2, "R6"); idle(3, 4'h0, "R6");
    idle(1, 4'h4, "R6"); idle(2, 4'h0, "R6");
    idle(1, 4'h8, "R8"); idle(3, 4'h0, "R8");

    // R6: B completes first
    cyc(1'b1, 4'h0, "R6");
    idle(1, 4'h4, "R6"); idle(1, 4'h8, "R6"); idle(3, 4'h0, "R6");
    idle(1, 4'h1, "R6"); idle(1, 4'h0, "R6"); idle(1, 4'h2, "R6");
    idle(3, 4'h0, "R8");

    // R7: simultaneous completion
    cyc(1'b1, 4'h0, "R7");
    idle(1, 4'h5, "R7"); idle(2, 4'h0, "R7"); idle(1, 4'hA, "R7");
    idle(4, 4'h0, "R7");

    // R3: second buttons pressed before first
    cyc(1'b1, 4'h0, "R3");
    idle(3, 4'hA, "R3"); idle(2, 4'h0, "R3");
    idle(1, 4'h5, "R3"); idle(2, 4'h0, "R3");
    idle(1, 4'hA, "R3"); idle(3, 4'h0, "R3");

    // R4, R9: all held at start, then held long after the pulse
    cyc(1'b1, 4'hF, "R4");
    idle(1, 4'hF, "R4");
    idle(6, 4'hF, "R9"); idle(2, 4'h0, "R9");

    // R10: restart in mid-run drops A's progress
    cyc(1'b1, 4'h0, "R10");
    idle(1, 4'h3, "R10"); idle(1, 4'h0, "R10");
    cyc(1'b1, 4'h0, "R10");
    idle(1, 4'hC, "R10"); idle(4, 4'h0, "R10");
    idle(1, 4'h3, "R10"); idle(3, 4'h0, "R10");

    // Back-to-back starts with everything held
    cyc(1'b1, 4'hF, "R8"); cyc(1'b1, 4'hF, "R8"); cyc(1'b0, 4'h0, "R8");
    idle(2, 4'h0, "R8");

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] b;
      bit st;
      st = ($urandom % 16) == 0;
      for (int j = 0; j < 4; j++) b[j] = ($urandom % 4) == 0;
      cyc(st, b, "R6");
    end
    idle(3, 4'h0, "R9");
    finish_run();
  end
endmodule